// File: doc/BRIEF.md
# Joined-Stream Complex Multiplier

This block multiplies a stream of complex samples by a stream of complex oscillator values. Each stream arrives on its own AXI-Stream input, and the two streams are consumed strictly in pairs. A pair is taken only when both inputs are valid and the output side is accepting data, so the streams stay aligned sample for sample. The products go out on a single AXI-Stream output.

The sample stream uses 24-bit lanes, each holding a 21-bit signed value with 15 fractional bits. The oscillator stream uses 16-bit signed lanes with 14 fractional bits. Each output component is the exact 38-bit complex-product component with its six lowest bits removed. That leaves a 32-bit value with 23 fractional bits.

The datapath is a fixed four-stage pipeline. A low output tready freezes every stage at once.

Top module: `cplx_join_mult`

## Requirements
- R1: Sample input `s_a_tdata` holds the in-phase part in bits [23:0] and the quadrature part in bits [47:24]. Only the low 21 bits of each lane (bits [20:0] and [44:24]) are used, as signed values. Bits [23:21] and [47:45] have no effect on the output.
- R2: Oscillator input `s_b_tdata` holds the real (cosine) part in bits [15:0] and the imaginary (sine) part in bits [31:16]. Both are signed.
- R3: With signed operands, the real result is I·cos − Q·sin and the imaginary result is I·sin + Q·cos, each computed at 38 bits. Each output component is bits [37:6] of its result. The real component goes in `m_y_tdata[31:0]` and the imaginary component in `m_y_tdata[63:32]`.
- R4: `s_a_tready` is high exactly when `s_b_tvalid` and `m_y_tready` are both high. `s_b_tready` is high exactly when `s_a_tvalid` and `m_y_tready` are both high. A transfer on either input therefore always occurs together with one on the other.
- R5: The output `m_y_tlast` is the OR of the two input tlast flags of the pair that produced the result.
- R6: With `m_y_tready` held high, a result appears on the output exactly four clock edges after its input pair was taken. The edge that takes the pair counts as the first.
- R7: While `m_y_tready` is low, no input is accepted, and a valid output keeps its data and tlast unchanged.
- R8: An active-high synchronous `rst` clears every valid flag in the pipeline. After reset `m_y_tvalid` is low, and results that were in flight are discarded.
- R9: Results leave in the order their input pairs were taken. None is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_a_tdata | input | 48 | Sample: Q in upper lane, I in lower lane |
| s_a_tlast | input | 1 | Sample end-of-packet flag |
| s_a_tvalid | input | 1 | Sample valid |
| s_a_tready | output | 1 | Sample ready |
| s_b_tdata | input | 32 | Oscillator: sine upper, cosine lower |
| s_b_tlast | input | 1 | Oscillator end-of-packet flag |
| s_b_tvalid | input | 1 | Oscillator valid |
| s_b_tready | output | 1 | Oscillator ready |
| m_y_tdata | output | 64 | Product: imaginary upper, real lower |
| m_y_tlast | output | 1 | Product end-of-packet flag |
| m_y_tvalid | output | 1 | Product valid |
| m_y_tready | input | 1 | Downstream ready |

## Verification
The assertions check on every cycle that the two readies obey the join rule and that a stalled output keeps its data and tlast. They also check that output valid follows a four-deep history of accepted pairs, which covers both the latency and the clearing by reset. Only the bench scenarios can show that the arithmetic is correct:
- the lane packing and truncation against known constants;
- that the upper lane bits are ignored under random data;
- the tlast OR across all four flag combinations;
- that results stay in order and none is lost when valids and ready toggle randomly or a reset cuts through packets in flight.

// File: rtl/cjm_pkg.sv
package cjm_pkg;
    // Number of register stages between the joined input and the output
    localparam int unsigned CJM_DEPTH = 4;

    typedef struct packed {
        logic vld;
        logic last;
    } cjm_tag_t;
endpackage

// File: rtl/cjm_join.sv
module cjm_join (
    input  logic a_vld,
    input  logic b_vld,
    input  logic adv,
    output logic a_rdy,
    output logic b_rdy,
    output logic fire
);
    // Each side is ready only when its partner is offering data and the
    // pipeline moves this cycle
    always_comb begin
        a_rdy = b_vld & adv;
        b_rdy = a_vld & adv;
        fire  = a_vld & b_vld & adv;
    end
endmodule

// File: rtl/cjm_datapath.sv
module cjm_datapath
    import cjm_pkg::*;
#(
    parameter int A_LANE = 24,
    parameter int A_BITS = 21,
    parameter int B_BITS = 16,
    parameter int DROP   = 6,
    localparam int P_W    = A_BITS + B_BITS,
    localparam int FULL_W = P_W + 1,
    localparam int OUT_W  = FULL_W - DROP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  adv,
    input  logic                  in_fire,
    input  logic [2*A_LANE-1:0]   in_a,
    input  logic [2*B_BITS-1:0]   in_b,
    input  logic                  in_last,
    output logic                  out_vld,
    output logic                  out_last,
    output logic [2*OUT_W-1:0]    out_data
);
    typedef struct packed {
        cjm_tag_t                   t1;
        logic signed [A_BITS-1:0]   ai;
        logic signed [A_BITS-1:0]   aq;
        logic signed [B_BITS-1:0]   br;
        logic signed [B_BITS-1:0]   bi;
        cjm_tag_t                   t2;
        logic signed [P_W-1:0]      p_ir;
        logic signed [P_W-1:0]      p_qi;
        logic signed [P_W-1:0]      p_ii;
        logic signed [P_W-1:0]      p_qr;
        cjm_tag_t                   t3;
        logic signed [FULL_W-1:0]   re;
        logic signed [FULL_W-1:0]   im;
        cjm_tag_t                   t4;
        logic [2*OUT_W-1:0]         dout;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Lane guard bits carry only sign extension and are not used
    logic unused_lane_hi;
    assign unused_lane_hi = ^{in_a[A_LANE-1:A_BITS], in_a[2*A_LANE-1:A_LANE+A_BITS]};

    // Operand routing for the four partial products
    logic signed [A_BITS-1:0] mul_a [4];
    logic signed [B_BITS-1:0] mul_b [4];
    logic signed [P_W-1:0]    mul_p [4];

    always_comb begin
        mul_a[0] = pipe_q.ai;  mul_b[0] = pipe_q.br;
        mul_a[1] = pipe_q.aq;  mul_b[1] = pipe_q.bi;
        mul_a[2] = pipe_q.ai;  mul_b[2] = pipe_q.bi;
        mul_a[3] = pipe_q.aq;  mul_b[3] = pipe_q.br;
    end

    for (genvar k = 0; k < 4; k++) begin : g_prod
        assign mul_p[k] = P_W'(mul_a[k]) * P_W'(mul_b[k]);
    end

    always_comb begin
        pipe_d = pipe_q;
        if (adv) begin
            // stage 1: operand capture
            pipe_d.t1.vld  = in_fire;
            pipe_d.t1.last = in_last;
            if (in_fire) begin
                pipe_d.ai = in_a[A_BITS-1:0];
                pipe_d.aq = in_a[A_LANE+A_BITS-1:A_LANE];
                pipe_d.br = in_b[B_BITS-1:0];
                pipe_d.bi = in_b[2*B_BITS-1:B_BITS];
            end
            // stage 2: partial products
            pipe_d.t2   = pipe_q.t1;
            pipe_d.p_ir = mul_p[0];
            pipe_d.p_qi = mul_p[1];
            pipe_d.p_ii = mul_p[2];
            pipe_d.p_qr = mul_p[3];
            // stage 3: full-precision sums
            pipe_d.t3 = pipe_q.t2;
            pipe_d.re = FULL_W'(pipe_q.p_ir) - FULL_W'(pipe_q.p_qi);
            pipe_d.im = FULL_W'(pipe_q.p_ii) + FULL_W'(pipe_q.p_qr);
            // stage 4: drop low bits and pack
            pipe_d.t4   = pipe_q.t3;
            pipe_d.dout = {pipe_q.im[FULL_W-1:DROP], pipe_q.re[FULL_W-1:DROP]};
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
        if (rst) begin
            pipe_q.t1.vld <= 1'b0;
            pipe_q.t2.vld <= 1'b0;
            pipe_q.t3.vld <= 1'b0;
            pipe_q.t4.vld <= 1'b0;
        end
    end

    assign out_vld  = pipe_q.t4.vld;
    assign out_last = pipe_q.t4.last;
    assign out_data = pipe_q.dout;
endmodule

// File: rtl/cplx_join_mult.sv
module cplx_join_mult #(
    parameter int A_LANE = 24,
    parameter int A_BITS = 21,
    parameter int B_BITS = 16,
    parameter int DROP   = 6,
    localparam int OUT_W = A_BITS + B_BITS + 1 - DROP
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2*A_LANE-1:0]   s_a_tdata,
    input  logic                  s_a_tlast,
    input  logic                  s_a_tvalid,
    output logic                  s_a_tready,
    input  logic [2*B_BITS-1:0]   s_b_tdata,
    input  logic                  s_b_tlast,
    input  logic                  s_b_tvalid,
    output logic                  s_b_tready,
    output logic [2*OUT_W-1:0]    m_y_tdata,
    output logic                  m_y_tlast,
    output logic                  m_y_tvalid,
    input  logic                  m_y_tready
);
    logic join_fire;

    // The whole pipeline advances only when downstream accepts
    cjm_join u_join (
        .a_vld (s_a_tvalid),
        .b_vld (s_b_tvalid),
        .adv   (m_y_tready),
        .a_rdy (s_a_tready),
        .b_rdy (s_b_tready),
        .fire  (join_fire)
    );

    cjm_datapath #(
        .A_LANE (A_LANE),
        .A_BITS (A_BITS),
        .B_BITS (B_BITS),
        .DROP   (DROP)
    ) u_dp (
        .clk      (clk),
        .rst      (rst),
        .adv      (m_y_tready),
        .in_fire  (join_fire),
        .in_a     (s_a_tdata),
        .in_b     (s_b_tdata),
        .in_last  (s_a_tlast | s_b_tlast),
        .out_vld  (m_y_tvalid),
        .out_last (m_y_tlast),
        .out_data (m_y_tdata)
    );
endmodule

// File: rtl/cjm_chk.sv
module cjm_chk
    import cjm_pkg::*;
#(
    parameter int OUT_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               s_a_tvalid,
    input logic               s_a_tready,
    input logic               s_b_tvalid,
    input logic               s_b_tready,
    input logic               m_y_tvalid,
    input logic               m_y_tready,
    input logic               m_y_tlast,
    input logic [2*OUT_W-1:0] m_y_tdata
);
    // History of accepted pairs, shifted whenever downstream is ready
    logic [CJM_DEPTH-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst)
            hist_q <= '0;
        else if (m_y_tready)
            hist_q <= {hist_q[CJM_DEPTH-2:0], s_a_tvalid & s_a_tready & s_b_tvalid & s_b_tready};
    end

    // R4
    a_join_chk: assert property (@(posedge clk) disable iff (rst)
        s_a_tready |-> (s_b_tvalid && m_y_tready));

    // R4
    b_join_chk: assert property (@(posedge clk) disable iff (rst)
        s_b_tready |-> (s_a_tvalid && m_y_tready));

    // R4
    pair_take_chk: assert property (@(posedge clk) disable iff (rst)
        (s_a_tvalid && s_b_tvalid && m_y_tready) |-> (s_a_tready && s_b_tready));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (m_y_tvalid && !m_y_tready) |=> (m_y_tvalid && $stable(m_y_tdata) && $stable(m_y_tlast)));

    // R7
    stall_block_chk: assert property (@(posedge clk) disable iff (rst)
        !m_y_tready |-> (!s_a_tready && !s_b_tready));

    // R6 R8
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        m_y_tvalid == hist_q[CJM_DEPTH-1]);
endmodule

bind cplx_join_mult cjm_chk #(.OUT_W(OUT_W)) u_cjm_chk (
    .clk        (clk),
    .rst        (rst),
    .s_a_tvalid (s_a_tvalid),
    .s_a_tready (s_a_tready),
    .s_b_tvalid (s_b_tvalid),
    .s_b_tready (s_b_tready),
    .m_y_tvalid (m_y_tvalid),
    .m_y_tready (m_y_tready),
    .m_y_tlast  (m_y_tlast),
    .m_y_tdata  (m_y_tdata)
);

// File: tb/test_cplx_join_mult.sv
module test_cplx_join_mult;
    localparam time CLK_T = 20ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [47:0] a_d = '0;
    logic        a_l = 1'b0;
    logic        a_v = 1'b0;
    logic        a_r;
    logic [31:0] b_d = '0;
    logic        b_l = 1'b0;
    logic        b_v = 1'b0;
    logic        b_r;
    logic [63:0] y_d;
    logic        y_l;
    logic        y_v;
    logic        y_r = 1'b1;

    int n_chk  = 0;
    int n_fail = 0;
    logic [64:0] exp_q[$];

    always #(CLK_T/2) clk = ~clk;

    cplx_join_mult i_cplx_join_mult (
        .clk(clk), .rst(rst),
        .s_a_tdata(a_d), .s_a_tlast(a_l), .s_a_tvalid(a_v), .s_a_tready(a_r),
        .s_b_tdata(b_d), .s_b_tlast(b_l), .s_b_tvalid(b_v), .s_b_tready(b_r),
        .m_y_tdata(y_d), .m_y_tlast(y_l), .m_y_tvalid(y_v), .m_y_tready(y_r)
    );

    task automatic check(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference product from the requirements (R1, R2, R3)
    function automatic logic [63:0] ref_prod(input logic [47:0] a, input logic [31:0] b);
        longint ai, aq, br, bi, re, im;
        ai = longint'($signed(a[20:0]));
        aq = longint'($signed(a[44:24]));
        br = longint'($signed(b[15:0]));
        bi = longint'($signed(b[31:16]));
        re = (ai * br - aq * bi) >>> 6;
        im = (ai * bi + aq * br) >>> 6;
        return {im[31:0], re[31:0]};
    endfunction

    // Scoreboard: driver side pushes on accepted pairs, monitor side pops on output transfers
    always @(negedge clk) begin
        if (!rst) begin
            check("R4 sample ready", {64'd0, a_r}, {64'd0, b_v & y_r});
            check("R4 osc ready",    {64'd0, b_r}, {64'd0, a_v & y_r});
            if (a_v && a_r)
                exp_q.push_back({a_l | b_l, ref_prod(a_d, b_d)});
            if (y_v && y_r) begin
                if (exp_q.size() == 0) begin
                    check("R9 unexpected output", {y_l, y_d}, 65'd0);
                end else begin
                    logic [64:0] e;
                    e = exp_q.pop_front();
                    check("R3 product data", {1'b0, y_d}, {1'b0, e[63:0]});
                    check("R5 tlast", {64'd0, y_l}, {64'd0, e[64]});
                end
            end
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_T * 200000);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    task automatic push_pair(input logic [47:0] a, input logic [31:0] b, input logic la, input logic lb);
        a_d = a; b_d = b; a_l = la; b_l = lb; a_v = 1'b1; b_v = 1'b1;
        forever begin
            @(negedge clk);
            if (a_r) break;
        end
        @(posedge clk); #1;
        a_v = 1'b0; b_v = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        logic [47:0] sa;
        logic [31:0] sb;
        logic [63:0] e_hold;

        // Reset state (R8, R4)
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        check("R8 valid in reset", {64'd0, y_v}, 65'd0);
        @(posedge clk); #1;
        rst = 1'b0;
        a_v = 1'b1;
        @(negedge clk);
        check("R4 no ready without partner", {63'd0, a_r, b_r}, {63'd0, 1'b0, 1'b1});
        @(posedge clk); #1;
        a_v = 1'b0;

        // Latency and a known constant: I=1.0, cos=1.0 -> real 1.0 at 23 fraction bits (R6, R3)
        push_pair({24'd0, 24'h008000}, {16'd0, 16'h4000}, 1'b0, 1'b0);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R6 latency", {64'd0, y_v}, {64'd0, (k == 4)});
            if (k == 4) check("R3 known value", {1'b0, y_d}, {1'b0, 64'h00000000_00800000});
        end
        idle(2);

        // Quadrature path: Q=-0.5, sin=+0.5 -> real +0.25, imag 0 (R2, R3)
        push_pair({24'hFFC000, 24'd0}, {16'h2000, 16'd0}, 1'b0, 1'b0);
        idle(4);
        @(negedge clk);
        check("R2 sine lane", {1'b0, y_d}, {1'b0, 64'h00000000_00200000});
        idle(2);

        // Guard bits in the lanes are ignored (R1)
        sa = {24'h0ABCDE, 24'h1F0123};
        sb = 32'h9ABC_7F11;
        push_pair(sa, sb, 1'b0, 1'b0);
        idle(4);
        @(negedge clk);
        check("R1 guard bits ignored", {1'b0, y_d}, {1'b0, ref_prod({3'b000, sa[44:24], 3'b000, sa[20:0]}, sb)});
        push_pair({3'b111, sa[44:24], 3'b111, sa[20:0]}, sb, 1'b0, 1'b0);
        idle(4);
        @(negedge clk);
        check("R1 guard bits set", {1'b0, y_d}, {1'b0, ref_prod({3'b000, sa[44:24], 3'b000, sa[20:0]}, sb)});

        // tlast combinations and extreme operands (R5, R3)
        push_pair({24'h100000, 24'h100000}, {16'h8000, 16'h8000}, 1'b0, 1'b0);
        push_pair({24'h0FFFFF, 24'h100000}, {16'h7FFF, 16'h8000}, 1'b1, 1'b0);
        push_pair({24'h100000, 24'h0FFFFF}, {16'h8000, 16'h7FFF}, 1'b0, 1'b1);
        push_pair({24'h0FFFFF, 24'h0FFFFF}, {16'h7FFF, 16'h7FFF}, 1'b1, 1'b1);
        idle(8);

        // Stall: nothing taken while downstream is blocked, output held (R7)
        y_r = 1'b0;
        sa = 48'h000123_7FF456;
        sb = 32'h1234_C321;
        a_d = sa; b_d = sb; a_v = 1'b1; b_v = 1'b1; a_l = 1'b1; b_l = 1'b0;
        repeat (4) begin
            @(negedge clk);
            check("R7 no accept during stall", {63'd0, a_r, b_r}, 65'd0);
        end
        @(posedge clk); #1;
        y_r = 1'b1;
        @(posedge clk); #1;
        a_d = 48'h0F0F0F_070707; a_l = 1'b0;
        @(posedge clk); #1;
        a_v = 1'b0; b_v = 1'b0;
        @(posedge clk);
        @(posedge clk); #1;
        y_r = 1'b0;
        e_hold = ref_prod(sa, sb);
        repeat (5) begin
            @(negedge clk);
            check("R7 held output", {y_l, y_d}, {1'b1, e_hold});
        end
        @(posedge clk); #1;
        y_r = 1'b1;
        idle(8);

        // Reset with results in flight discards them (R8)
        push_pair(48'h000111_000222, 32'h0333_0444, 1'b0, 1'b0);
        push_pair(48'h000555_000666, 32'h0777_0888, 1'b0, 1'b0);
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        exp_q.delete();
        repeat (6) begin
            @(negedge clk);
            check("R8 flushed by reset", {64'd0, y_v}, 65'd0);
        end

        // Random traffic on both inputs and on downstream ready (R9, R1, R3, R5)
        begin
            logic took;
            for (int c = 0; c < 600; c++) begin
                @(negedge clk);
                took = a_v && a_r;
                @(posedge clk); #1;
                if (!a_v || took) begin
                    a_v = ($urandom % 4) != 0;
                    a_d = {$urandom, $urandom};
                    a_l = $urandom % 2;
                end
                if (!b_v || took) begin
                    b_v = ($urandom % 3) != 0;
                    b_d = $urandom;
                    b_l = ($urandom % 5) == 0;
                end
                y_r = ($urandom % 4) != 0;
            end
        end
        a_v = 1'b0; b_v = 1'b0; y_r = 1'b1;
        idle(10);
        @(negedge clk);
        check("R9 all results delivered", 65'(exp_q.size()), 65'd0);

        finish_run();
    end
endmodule